// File: doc/BRIEF.md
# Double-data-rate sample commutator with frame strobe

This block sits between a converter that delivers signed 12-bit samples at two per clock and a filter bank that works at a rate 48 times lower. Each fast clock carries an earlier sample and a later sample, and each has its own valid bit. All state is held in rising-edge registers. The block pairs consecutive valid samples into an even lane and an odd lane. Pairing starts from the first valid sample of a burst, whichever half of the clock that sample occupies. Each pair shifts two places down a 48-tap delay line.

Once 24 pairs, that is 48 fresh samples, have entered the line, the block latches all taps into a held output frame. It then raises a one-cycle strobe for the slow domain and advances a frame counter. Any half-cycle without a valid sample ends the burst and drops the partly gathered frame. The next burst realigns from its own first sample.

Top module: `ddr_commutator`

## Requirements
- R1: While reset is high at a clock edge, the next cycle shows `frame_stb` low, `frame_cnt` zero and every tap of `frame_o` zero.
- R2: Within a cycle, `in_smp0` (qualified by `in_vld[0]`) is earlier in the stream than `in_smp1` (qualified by `in_vld[1]`). A sample whose valid bit is low is ignored.
- R3: A burst may begin on either half of a cycle: `in_vld` = 2'b11 or 2'b10 after an invalid half. Its first valid sample is always sample 0 of the burst.
- R4: `frame_stb` is high for exactly the one cycle after the clock edge that carries sample 48f+47 of a burst (f = 0, 1, …). It is low otherwise.
- R5: When `frame_stb` is high, bits [12k+11:12k] of `frame_o` hold burst sample 48f+47−k. Tap 0 is the newest sample and tap 47 the oldest.
- R6: `frame_o` and `frame_cnt` do not change in any cycle in which `frame_stb` is low.
- R7: `frame_cnt` rises by one with each strobe and wraps modulo 2^CNT_W.
- R8: Any half with its valid bit low discards the samples gathered for the current frame. The next strobe needs 48 new samples after the burst restarts.
- R9: Cycles with `in_vld` = 2'b00 never lead to a strobe. They change no output.
- R10: A frame whose last sample is on the first half of a cycle with `in_vld` = 2'b01 is still issued.
- R11: Under an unbroken burst, strobes are exactly 24 cycles apart.
- R12: Reset in the middle of a burst drops the partial frame and clears outputs. The first frame after reset needs 48 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 2 | Valid bits: [0] for the first half, [1] for the second half |
| in_smp0 | input | SMP_W | Sample on the first half of the cycle |
| in_smp1 | input | SMP_W | Sample on the second half of the cycle |
| frame_o | output | TAPS*SMP_W | Held frame, tap k at bits [SMP_W*k +: SMP_W] |
| frame_stb | output | 1 | One-cycle strobe for a new frame |
| frame_cnt | output | CNT_W | Count of frames issued since reset |

## Verification
The hardest state to reach is a burst that begins on the second half of a cycle. That burst must then end on the first half of a cycle at the exact moment its 48th sample arrives. The pair built across the cycle boundary and the break in the same cycle meet there.

The stimulus reaches this point with a burst that opens with `in_vld` = 2'b10, runs 23 full cycles, and closes with 2'b01. It also uses breaks of both polarities in the middle of a frame. Every half that is not valid carries a poison value, so any leak of it into a frame shows up in the comparison.

// File: rtl/ddr_comm_pkg.sv
package ddr_comm_pkg;

    localparam int unsigned DEF_SMP_W = 12;
    localparam int unsigned DEF_TAPS  = 48;
    localparam int unsigned DEF_CNT_W = 16;

    typedef enum logic {
        ALN_EMPTY = 1'b0,
        ALN_HELD  = 1'b1
    } align_e;

    function automatic int unsigned pairs_of(input int unsigned taps);
        return taps / 2;
    endfunction

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ddr_pair_align.sv
module ddr_pair_align
    import ddr_comm_pkg::*;
#(
    parameter int unsigned SMP_W = DEF_SMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       in_vld,
    input  logic [SMP_W-1:0] in_smp0,
    input  logic [SMP_W-1:0] in_smp1,
    output logic             pair_vld,
    output logic [SMP_W-1:0] pair_even,
    output logic [SMP_W-1:0] pair_odd,
    output logic             burst_brk
);

    align_e             st_q, st_n, st_mid;
    logic [SMP_W-1:0]   held_q, held_n, held_mid;

    always_comb begin
        pair_vld  = 1'b0;
        pair_even = '0;
        pair_odd  = '0;
        st_mid    = st_q;
        held_mid  = held_q;
        // first half of the cycle
        if (in_vld[0]) begin
            if (st_q == ALN_HELD) begin
                pair_vld  = 1'b1;
                pair_even = held_q;
                pair_odd  = in_smp0;
                st_mid    = ALN_EMPTY;
            end else begin
                held_mid  = in_smp0;
                st_mid    = ALN_HELD;
            end
        end else begin
            st_mid = ALN_EMPTY;
        end
        // second half of the cycle
        st_n   = st_mid;
        held_n = held_mid;
        if (in_vld[1]) begin
            if (st_mid == ALN_HELD) begin
                pair_vld  = 1'b1;
                pair_even = held_mid;
                pair_odd  = in_smp1;
                st_n      = ALN_EMPTY;
            end else begin
                held_n    = in_smp1;
                st_n      = ALN_HELD;
            end
        end else begin
            st_n = ALN_EMPTY;
        end
    end

    assign burst_brk = ~&in_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ALN_EMPTY;
            held_q <= '0;
        end else begin
            st_q   <= st_n;
            held_q <= held_n;
        end
    end

endmodule

// File: rtl/ddr_tap_chain.sv
module ddr_tap_chain
    import ddr_comm_pkg::*;
#(
    parameter int unsigned SMP_W = DEF_SMP_W,
    parameter int unsigned TAPS  = DEF_TAPS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift_en,
    input  logic [SMP_W-1:0]           even_smp,
    input  logic [SMP_W-1:0]           odd_smp,
    output logic [TAPS-1:0][SMP_W-1:0] tap_nxt
);

    logic [TAPS-1:0][SMP_W-1:0] tap_q;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_newest
            assign tap_nxt[k] = shift_en ? odd_smp : tap_q[k];
        end else if (k == 1) begin : g_second
            assign tap_nxt[k] = shift_en ? even_smp : tap_q[k];
        end else begin : g_delay
            assign tap_nxt[k] = shift_en ? tap_q[k-2] : tap_q[k];
        end

        always_ff @(posedge clk) begin
            if (rst) tap_q[k] <= '0;
            else     tap_q[k] <= tap_nxt[k];
        end
    end

endmodule

// File: rtl/ddr_frame_hold.sv
module ddr_frame_hold
    import ddr_comm_pkg::*;
#(
    parameter int unsigned SMP_W = DEF_SMP_W,
    parameter int unsigned TAPS  = DEF_TAPS,
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pair_vld,
    input  logic                       burst_brk,
    input  logic [TAPS-1:0][SMP_W-1:0] tap_nxt,
    output logic [TAPS-1:0][SMP_W-1:0] frame_q,
    output logic                       frame_stb,
    output logic [CNT_W-1:0]           frame_cnt
);

    localparam int unsigned PAIRS = pairs_of(TAPS);
    localparam int unsigned PW    = idx_w(PAIRS);

    logic [PW-1:0] pcnt_q;
    logic          fire;

    assign fire = pair_vld && (pcnt_q == PW'(PAIRS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (burst_brk || fire) begin
            pcnt_q <= '0;
        end else if (pair_vld) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q   <= '0;
            frame_stb <= 1'b0;
            frame_cnt <= '0;
        end else begin
            frame_stb <= fire;
            if (fire) begin
                frame_q   <= tap_nxt;
                frame_cnt <= frame_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ddr_commutator.sv
module ddr_commutator
    import ddr_comm_pkg::*;
#(
    parameter int unsigned SMP_W = DEF_SMP_W,
    parameter int unsigned TAPS  = DEF_TAPS,
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              in_vld,
    input  logic [SMP_W-1:0]        in_smp0,
    input  logic [SMP_W-1:0]        in_smp1,
    output logic [TAPS*SMP_W-1:0]   frame_o,
    output logic                    frame_stb,
    output logic [CNT_W-1:0]        frame_cnt
);

    logic                       pair_vld;
    logic [SMP_W-1:0]           pair_even;
    logic [SMP_W-1:0]           pair_odd;
    logic                       burst_brk;
    logic [TAPS-1:0][SMP_W-1:0] tap_nxt;
    logic [TAPS-1:0][SMP_W-1:0] frame_q;

    ddr_pair_align #(.SMP_W(SMP_W)) u_align (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (in_vld),
        .in_smp0   (in_smp0),
        .in_smp1   (in_smp1),
        .pair_vld  (pair_vld),
        .pair_even (pair_even),
        .pair_odd  (pair_odd),
        .burst_brk (burst_brk)
    );

    ddr_tap_chain #(.SMP_W(SMP_W), .TAPS(TAPS)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (pair_vld),
        .even_smp (pair_even),
        .odd_smp  (pair_odd),
        .tap_nxt  (tap_nxt)
    );

    ddr_frame_hold #(.SMP_W(SMP_W), .TAPS(TAPS), .CNT_W(CNT_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .pair_vld  (pair_vld),
        .burst_brk (burst_brk),
        .tap_nxt   (tap_nxt),
        .frame_q   (frame_q),
        .frame_stb (frame_stb),
        .frame_cnt (frame_cnt)
    );

    assign frame_o = frame_q;

endmodule

// File: rtl/ddr_commutator_chk.sv
module ddr_commutator_chk
    import ddr_comm_pkg::*;
#(
    parameter int unsigned SMP_W = DEF_SMP_W,
    parameter int unsigned TAPS  = DEF_TAPS,
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic [1:0]            in_vld,
    input logic [TAPS*SMP_W-1:0] frame_o,
    input logic                  frame_stb,
    input logic [CNT_W-1:0]      frame_cnt
);

    localparam int unsigned PAIRS = pairs_of(TAPS);
    localparam int unsigned GW    = idx_w(PAIRS + 1) + 1;

    logic [GW-1:0] stb_gap;
    logic [GW-1:0] idle_gap;
    logic          hist_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_gap  <= GW'(PAIRS);
            idle_gap <= '0;
            hist_ok  <= 1'b0;
        end else begin
            hist_ok <= 1'b1;
            if (frame_stb)                stb_gap <= GW'(1);
            else if (stb_gap < GW'(PAIRS)) stb_gap <= stb_gap + 1'b1;
            if (in_vld == 2'b00)           idle_gap <= '0;
            else if (idle_gap < GW'(PAIRS)) idle_gap <= idle_gap + 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!frame_stb && frame_cnt == '0 && frame_o == '0));

    p_stb_spacing_r11: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> stb_gap >= GW'(PAIRS));

    p_fresh_after_idle_r8: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> idle_gap >= GW'(PAIRS));

    p_idle_no_stb_r9: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && frame_stb) |-> $past(in_vld) != 2'b00);

    p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && frame_stb) |-> frame_cnt == CNT_W'($past(frame_cnt) + 1'b1));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && !frame_stb) |-> ($stable(frame_o) && $stable(frame_cnt)));

endmodule

bind ddr_commutator ddr_commutator_chk #(
    .SMP_W(SMP_W), .TAPS(TAPS), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .frame_o   (frame_o),
    .frame_stb (frame_stb),
    .frame_cnt (frame_cnt)
);

// File: tb/ddr_commutator_bench.sv
module ddr_commutator_bench;

    localparam int SMP_W = 12;
    localparam int TAPS  = 48;
    localparam int CNT_W = 4;
    localparam int FW    = TAPS * SMP_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       in_vld = 2'b00;
    logic [SMP_W-1:0] in_smp0 = '0;
    logic [SMP_W-1:0] in_smp1 = '0;
    logic [FW-1:0]    frame_o;
    logic             frame_stb;
    logic [CNT_W-1:0] frame_cnt;

    always #4 clk = ~clk;

    ddr_commutator #(.SMP_W(SMP_W), .TAPS(TAPS), .CNT_W(CNT_W)) u_ddr_commutator (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (in_vld),
        .in_smp0   (in_smp0),
        .in_smp1   (in_smp1),
        .frame_o   (frame_o),
        .frame_stb (frame_stb),
        .frame_cnt (frame_cnt)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic [SMP_W-1:0] hist[$];
    int               nsmp = 0;
    logic [FW-1:0]    exp_frame = '0;
    logic             exp_stb = 1'b0;
    logic [CNT_W-1:0] exp_cnt = '0;
    bit               armed = 0;
    string            cur_req = "R2";
    int               seq = 0;
    int               cyc = 0;
    int               stb_seen = 0;
    int               last_stb = -1;
    bit               track_gap = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        if (!armed) return;
        chk(frame_stb === exp_stb, {"R4 ", cur_req}, "strobe",
            FW'(frame_stb), FW'(exp_stb));
        chk(frame_cnt === exp_cnt, "R7", "frame count",
            FW'(frame_cnt), FW'(exp_cnt));
        chk(frame_o === exp_frame, exp_stb ? {"R5 ", cur_req} : "R6",
            "frame", frame_o, exp_frame);
        if (frame_stb === 1'b1) begin
            stb_seen++;
            if (track_gap && last_stb >= 0)
                chk(cyc - last_stb == 24, "R11", "strobe interval",
                    FW'(cyc - last_stb), FW'(24));
            last_stb = cyc;
        end
    endtask

    task automatic model_half(input bit v, input logic [SMP_W-1:0] s);
        if (!v) begin
            nsmp = 0;
            hist.delete();
            return;
        end
        hist.push_back(s);
        if (hist.size() > TAPS) void'(hist.pop_front());
        nsmp++;
        if (nsmp % TAPS == 0) begin
            for (int k = 0; k < TAPS; k++)
                exp_frame[k*SMP_W +: SMP_W] = hist[TAPS-1-k];
            exp_stb = 1'b1;
            exp_cnt = exp_cnt + 1'b1;
        end
    endtask

    task automatic step(input bit r, input logic [1:0] v,
                        input logic [SMP_W-1:0] a, input logic [SMP_W-1:0] b);
        @(negedge clk);
        compare();
        cyc++;
        rst = r; in_vld = v; in_smp0 = a; in_smp1 = b;
        exp_stb = 1'b0;
        if (r) begin
            nsmp = 0; hist.delete();
            exp_frame = '0; exp_cnt = '0;
            armed = 1;
        end else begin
            model_half(v[0], a);
            model_half(v[1], b);
        end
    endtask

    task automatic feed(input logic [1:0] v);
        logic [SMP_W-1:0] a, b;
        a = 12'hBAD; b = 12'hBAD;
        if (v[0]) begin a = SMP_W'(seq * 1103 + 29); seq++; end
        if (v[1]) begin b = SMP_W'(seq * 1103 + 29); seq++; end
        step(0, v, a, b);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        int s0;
        repeat (3) step(1, 2'b00, '0, '0);
        step(0, 2'b00, '0, '0);
        chk(frame_stb === 1'b0, "R1", "strobe after reset", FW'(frame_stb), '0);
        chk(frame_cnt === '0, "R1", "count after reset", FW'(frame_cnt), '0);
        chk(frame_o === '0, "R1", "frame after reset", frame_o, '0);

        // R2 R7 R11: long unbroken burst, counter wraps
        cur_req = "R2"; track_gap = 1;
        for (int i = 0; i < 24 * 18; i++) feed(2'b11);
        track_gap = 0;

        // R9: idle cycles
        cur_req = "R9";
        feed(2'b00);
        s0 = stb_seen;
        for (int i = 0; i < 10; i++) feed(2'b00);
        chk(stb_seen == s0, "R9", "strobes while idle", FW'(stb_seen - s0), '0);

        // R3: burst opening on the second half
        cur_req = "R3";
        feed(2'b10);
        for (int i = 0; i < 60; i++) feed(2'b11);
        for (int i = 0; i < 3; i++) feed(2'b00);

        // R10: 48th sample on the first half, second half invalid
        cur_req = "R10";
        s0 = stb_seen;
        feed(2'b10);
        for (int i = 0; i < 23; i++) feed(2'b11);
        feed(2'b01);
        for (int i = 0; i < 3; i++) feed(2'b00);
        chk(stb_seen - s0 == 1, "R10", "frames from short burst",
            FW'(stb_seen - s0), FW'(1));

        // R8: breaks of both polarities in the middle of a frame
        cur_req = "R8";
        s0 = stb_seen;
        for (int i = 0; i < 15; i++) feed(2'b11);
        feed(2'b01);
        for (int i = 0; i < 20; i++) feed(2'b11);
        feed(2'b10);
        for (int i = 0; i < 20; i++) feed(2'b11);
        chk(stb_seen == s0, "R8", "strobes before fresh frame",
            FW'(stb_seen - s0), '0);
        for (int i = 0; i < 6; i++) feed(2'b11);

        // R12: reset mid-burst
        cur_req = "R12";
        for (int i = 0; i < 10; i++) feed(2'b11);
        step(1, 2'b11, 12'h111, 12'h222);
        step(1, 2'b11, 12'h333, 12'h444);
        feed(2'b11);
        chk(frame_o === '0, "R12", "frame after mid reset", frame_o, '0);
        chk(frame_cnt === '0, "R12", "count after mid reset", FW'(frame_cnt), '0);
        for (int i = 0; i < 30; i++) feed(2'b11);
        feed(2'b00);
        feed(2'b00);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule